// File: doc/BRIEF.md
# Serial SPI Byte Memory Slave

This block is the slave side of a byte-addressed serial memory on an SPI bus. A host selects it with an active-low chip select. The host then clocks in an 8-bit command, an optional 16-bit address and data bytes. Reads shift bytes back on the serial output. Writes are stored as soon as each byte has been received, so the host can start its next command without polling for a busy state.

A status register holds three things: a write-enable latch, a two-bit field that protects a region of the array, and a bit that lets a write-protect pin lock the status register. A hold input freezes a transfer in the middle of a byte and lets it resume later. The storage is a synchronous byte array with 2**MEM_AW entries, indexed by the low address bits. All pins are sampled with the system clock `clk`, so the pins must already be synchronous to it.

Top module: `spi_fram_slave`

## Requirements
- R1: After reset the status register reads 0x00 and `so_oe` is low.
- R2: SPI modes 0 and 3 are both accepted, with SCK idling low or high at chip-select fall. SI is sampled on the rising SCK edge and SO changes on the falling edge. All bytes travel MSB first. Each SCK phase and each chip-select-high interval lasts at least two `clk` cycles.
- R3: While chip select is high, a partial command is dropped and `so_oe` is low. After an opcode other than 0x06, 0x04, 0x05, 0x01, 0x03 or 0x02, every remaining bit is ignored until chip select rises.
- R4: While the sampled hold input is low, SCK and chip-select changes are ignored and `so_oe` is low. Hold is sampled only while SCK is low. Once hold is released, the transfer continues from the same bit.
- R5: `so_oe` is high only while read data or status is being shifted out, and never during a write command.
- R6: Opcode 0x03 is followed by a 16-bit address. Data bytes then stream out, and the address increments after each byte, wrapping from 0xFFFF to 0x0000.
- R7: Opcode 0x02 is followed by a 16-bit address. Each received byte is stored at once and the address increments with the same wrap. A following command may start after the minimum chip-select-high gap.
- R8: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. The latch also clears when chip select rises after a 0x02 or 0x01 opcode. Array and status writes are ignored while the latch is clear.
- R9: Opcode 0x05 returns the status byte, repeated for as long as SCK runs. Bit 7 is the pin-lock bit, bits 3:2 are the protect field, bit 1 is the write-enable latch, and all other bits read 0.
- R10: Opcode 0x01 writes status bits 7, 3 and 2 from the next byte. The write is rejected while bit 7 is set and `wp_n` is low. `wp_n` has no effect on array writes.
- R11: Protect field 0 guards nothing, 1 guards 0xC000-0xFFFF, 2 guards 0x8000-0xFFFF and 3 guards the whole space. Writes to a guarded address are dropped.
- R12: The array holds 2**MEM_AW bytes and is indexed by the low MEM_AW bits of the 16-bit address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low transfer freeze |
| wp_n | input | 1 | Active-low status write lock |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (low = tri-state) |

## Verification
The bench builds the block with MEM_AW = 6, so the array has only 64 bytes. It writes and reads every location in one burst and recomputes each expected byte arithmetically from its address. With this small array, addresses such as 0xFFFF, 0x8002 and 0xC003 fall on distinct entries that are already checked. This brings the address wrap, aliasing and all four protect regions within reach of short transactions. The bench also runs every write and protection case under mode 0, repeats a burst in mode 3, and covers a hold in the middle of a byte with chip-select noise applied during the hold.

// File: rtl/spi_fram_slave.sv
module spi_fram_slave #(
  parameter int MEM_AW = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);

  localparam int DEPTH = 1 << MEM_AW;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {S_OPC, S_AHI, S_ALO, S_DAT, S_IGN} st_t;

  logic        sck_q, hold_q, cs_q;
  logic [2:0]  bcnt;
  logic [6:0]  sh;
  st_t         st;
  logic [7:0]  op;
  logic [15:0] addr;
  logic        wel, wpen, wr_txn, prot;
  logic [1:0]  bp;
  logic        oe_q, so_q;
  logic [7:0]  osh, rd_q;
  logic [7:0]  mem [DEPTH];

  wire             act     = !cs_q && hold_q;
  wire             rise    = act && sck && !sck_q;
  wire             fall    = act && !sck && sck_q;
  wire             done    = rise && (bcnt == 3'd7);
  wire [7:0]       byte_in = {sh, si};
  wire [7:0]       status  = {wpen, 3'b000, bp, wel, 1'b0};
  wire [7:0]       src     = (op == OP_RDSR) ? status : rd_q;
  wire             rd_op   = (op == OP_READ) || (op == OP_RDSR);
  wire             sr_ok   = wel && !(wpen && !wp_n);
  wire             mem_we  = done && st == S_DAT && op == OP_WRITE && wel && !prot;
  wire [MEM_AW-1:0] idx    = addr[MEM_AW-1:0];

  assign so    = so_q;
  assign so_oe = oe_q && hold_q;

  always_comb begin
    unique case (bp)
      2'd0:    prot = 1'b0;
      2'd1:    prot = &addr[15:14];
      2'd2:    prot = addr[15];
      default: prot = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      hold_q <= 1'b1;
      cs_q   <= 1'b1;
    end else begin
      sck_q <= sck;
      if (!sck)  hold_q <= hold_n;
      if (hold_q) cs_q  <= cs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_OPC;
      bcnt   <= 3'd0;
      sh     <= 7'd0;
      op     <= 8'd0;
      addr   <= 16'd0;
      wel    <= 1'b0;
      wpen   <= 1'b0;
      bp     <= 2'd0;
      wr_txn <= 1'b0;
      oe_q   <= 1'b0;
      so_q   <= 1'b0;
      osh    <= 8'd0;
    end else if (cs_q) begin
      st     <= S_OPC;
      bcnt   <= 3'd0;
      oe_q   <= 1'b0;
      wr_txn <= 1'b0;
      if (wr_txn) wel <= 1'b0;
    end else begin
      if (rise) begin
        sh   <= byte_in[6:0];
        bcnt <= bcnt + 3'd1;
      end
      if (done) begin
        unique case (st)
          S_OPC: begin
            op <= byte_in;
            unique case (byte_in)
              OP_WREN:  begin wel <= 1'b1; st <= S_IGN; end
              OP_WRDI:  begin wel <= 1'b0; st <= S_IGN; end
              OP_RDSR:  st <= S_DAT;
              OP_WRSR:  begin st <= S_DAT; wr_txn <= 1'b1; end
              OP_READ:  st <= S_AHI;
              OP_WRITE: begin st <= S_AHI; wr_txn <= 1'b1; end
              default:  st <= S_IGN;
            endcase
          end
          S_AHI: begin addr[15:8] <= byte_in; st <= S_ALO; end
          S_ALO: begin addr[7:0]  <= byte_in; st <= S_DAT; end
          S_DAT: begin
            if (op == OP_READ || op == OP_WRITE) addr <= addr + 16'd1;
            if (op == OP_WRSR) begin
              if (sr_ok) begin
                wpen <= byte_in[7];
                bp   <= byte_in[3:2];
              end
              st <= S_IGN;
            end
          end
          default: ;
        endcase
      end
      if (fall && st == S_DAT && rd_op) begin
        oe_q <= 1'b1;
        if (bcnt == 3'd0) begin
          so_q <= src[7];
          osh  <= {src[6:0], 1'b0};
        end else begin
          so_q <= osh[7];
          osh  <= {osh[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[idx] <= byte_in;
    rd_q <= mem[idx];
  end

  // R4
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && !cs_q) |=> ($stable(bcnt) && $stable(addr) && $stable(st)));

  // R3
  cs_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_q) |-> !so_oe);

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && st == S_DAT && (op == OP_READ || op == OP_WRITE)) |=> addr == $past(addr) + 16'd1);

  // R8
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_q) && wr_txn) |=> !wel);

  // R10
  sr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wpen && !wp_n) |=> ($stable(bp) && $stable(wpen)));

endmodule

// File: tb/sim_spi_fram_slave.sv
`timescale 1ns/1ps
module sim_spi_fram_slave;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_oe;
  int checks = 0, errors = 0;
  logic m3 = 1'b0, oe_any = 1'b0;
  logic b_wel = 1'b0, b_wpen = 1'b0;
  logic [1:0] b_bp = 2'd0;
  logic [7:0] model [64];

  spi_fram_slave #(.MEM_AW(6)) u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe));

  always #4 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [15:0] a, input logic [7:0] s);
    return (a[7:0] * 8'd7 + s) ^ a[15:8];
  endfunction

  function automatic logic guarded(input logic [1:0] b, input logic [15:0] a);
    return (b == 2'd3) || (b == 2'd2 && a >= 16'h8000) || (b == 2'd1 && a >= 16'hC000);
  endfunction

  function automatic logic [7:0] exp_sr();
    return {b_wpen, 3'b000, b_bp, b_wel, 1'b0};
  endfunction

  task automatic sbit(input logic b, output logic r);
    sck = 1'b0; si = b;
    repeat (3) @(negedge clk);
    r = so;
    if (so_oe) oe_any = 1'b1;
    sck = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic sbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      sbit(tx[i], b);
      rx[i] = b;
    end
  endtask

  task automatic cs_lo();
    sck = m3; oe_any = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cs_hi();
    if (!m3) begin sck = 1'b0; repeat (3) @(negedge clk); end
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 so_oe after cs high", {15'd0, so_oe}, 16'd0);
  endtask

  task automatic cmd(input logic [7:0] c);
    logic [7:0] d;
    cs_lo(); sbyte(c, d); cs_hi();
    if (c == 8'h06) b_wel = 1'b1;
    if (c == 8'h04) b_wel = 1'b0;
  endtask

  task automatic rdsr_chk(input string tag);
    logic [7:0] d, d2;
    cs_lo(); sbyte(8'h05, d); sbyte(8'h00, d); sbyte(8'h00, d2); cs_hi();
    chk(tag, {8'd0, d}, {8'd0, exp_sr()});
    chk("R9 status repeats", {8'd0, d2}, {8'd0, exp_sr()});
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    cs_lo(); sbyte(8'h01, d); sbyte(v, d); cs_hi();
    if (b_wel && !(b_wpen && !wp_n)) begin b_wpen = v[7]; b_bp = v[3:2]; end
    b_wel = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input int n, input logic [7:0] s);
    logic [7:0] d;
    cs_lo(); sbyte(8'h02, d); sbyte(a[15:8], d); sbyte(a[7:0], d);
    for (int i = 0; i < n; i++) begin
      logic [15:0] ai;
      ai = a + 16'(i);
      sbyte(pat(ai, s), d);
      if (b_wel && !guarded(b_bp, ai)) model[ai[5:0]] = pat(ai, s);
    end
    cs_hi();
    b_wel = 1'b0;
    chk("R5 no drive during write", {15'd0, oe_any}, 16'd0);
  endtask

  task automatic rd(input logic [15:0] a, input int n, input string tag);
    logic [7:0] d;
    cs_lo(); sbyte(8'h03, d); sbyte(a[15:8], d); sbyte(a[7:0], d);
    for (int i = 0; i < n; i++) begin
      logic [15:0] ai;
      ai = a + 16'(i);
      sbyte(8'h00, d);
      chk(tag, {ai[7:0], d}, {ai[7:0], model[ai[5:0]]});
    end
    cs_hi();
    chk("R5 drive during read", {15'd0, oe_any}, 16'd1);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk("R1 so_oe in reset", {15'd0, so_oe}, 16'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rdsr_chk("R1 status after reset");

    // R8 / R9 latch set and clear
    cmd(8'h06); rdsr_chk("R8 wel set");
    cmd(8'h04); rdsr_chk("R8 wel cleared by 0x04");

    // R7 / R6 / R12 full sweep of the 64-byte array
    cmd(8'h06); wr(16'h0000, 64, 8'h11);
    rdsr_chk("R8 wel cleared after write");
    rd(16'h0000, 64, "R7 burst write readback");
    rd(16'h1040, 4, "R12 aliased index");

    // R6 wrap across 0xFFFF
    cmd(8'h06); wr(16'hFFFF, 2, 8'h5A);
    rd(16'hFFFE, 3, "R6 wrap read");

    // R8 write with latch clear is dropped
    wr(16'h0010, 1, 8'hC3);
    rd(16'h0010, 1, "R8 write ignored without wel");

    // R3 unknown opcode then a valid one in the same select
    cs_lo(); sbyte(8'hFF, d); sbyte(8'h06, d); cs_hi();
    rdsr_chk("R3 unknown opcode ignored");

    // R3 partial write abandoned by chip select
    cmd(8'h06);
    cs_lo(); sbyte(8'h02, d); sbyte(8'h00, d); sbyte(8'h03, d);
    for (int i = 0; i < 4; i++) begin logic b; sbit(1'b0, b); end
    cs_hi(); b_wel = 1'b0;
    rdsr_chk("R3 abandoned write clears wel");
    rd(16'h0003, 1, "R3 abandoned byte not stored");

    // R2 mode 3
    m3 = 1'b1;
    cmd(8'h06); wr(16'h0020, 4, 8'h77);
    rd(16'h0020, 4, "R2 mode 3 burst");
    rdsr_chk("R2 mode 3 status");
    m3 = 1'b0;

    // R11 protect field sweep
    for (int p = 0; p < 4; p++) begin
      cmd(8'h06); wrsr({4'd0, 2'(p), 2'd0});
      rdsr_chk("R10 protect field written");
      for (int k = 0; k < 3; k++) begin
        logic [15:0] a;
        a = (k == 0) ? 16'h0001 : (k == 1) ? 16'h8002 : 16'hC003;
        cmd(8'h06); wr(a, 1, 8'(p * 16 + 3));
        rd(a, 1, "R11 protected region");
      end
    end
    cmd(8'h06); wrsr(8'h00);

    // R10 pin lock
    cmd(8'h06); wrsr(8'h80); rdsr_chk("R10 lock bit set");
    wp_n = 1'b0;
    cmd(8'h06); wrsr(8'h8C); rdsr_chk("R10 status write rejected");
    cmd(8'h06); wr(16'h0007, 1, 8'h99);
    rd(16'h0007, 1, "R10 pin leaves array writable");
    wp_n = 1'b1;
    cmd(8'h06); wrsr(8'h00); rdsr_chk("R10 unlocked write");
    wp_n = 1'b0;
    cmd(8'h06); wrsr(8'h04); rdsr_chk("R10 pin ignored when lock bit clear");
    wp_n = 1'b1;
    cmd(8'h06); wrsr(8'h00);

    // R4 hold in the middle of a read byte
    begin
      logic [7:0] r0, r1;
      cs_lo(); sbyte(8'h03, d); sbyte(8'h00, d); sbyte(8'h10, d);
      for (int i = 7; i >= 4; i--) begin logic b; sbit(1'b0, b); r0[i] = b; end
      sck = 1'b0; repeat (3) @(negedge clk);
      chk("R4 driving before hold", {15'd0, so_oe}, 16'd1);
      hold_n = 1'b0; repeat (3) @(negedge clk);
      chk("R4 tri-state in hold", {15'd0, so_oe}, 16'd0);
      for (int t = 0; t < 3; t++) begin
        si = 1'b1; sck = 1'b1; repeat (3) @(negedge clk);
        cs_n = t[0]; sck = 1'b0; repeat (3) @(negedge clk);
      end
      cs_n = 1'b0; repeat (3) @(negedge clk);
      hold_n = 1'b1; repeat (3) @(negedge clk);
      for (int i = 3; i >= 0; i--) begin logic b; sbit(1'b0, b); r0[i] = b; end
      sbyte(8'h00, r1);
      cs_hi();
      chk("R4 byte resumes after hold", {8'd0, r0}, {8'd0, model[16]});
      chk("R4 next byte after hold", {8'd0, r1}, {8'd0, model[17]});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule